// File: doc/BRIEF.md
# Paired Data Word Receive Framer

This block sits behind a link decoder that hands it one 20-bit frame per cycle, already classed as a data word, a control word, a fill word or an invalid frame. Data words carry 16 bits each. The sender always emits them in adjacent pairs, so the framer joins every two consecutive data words into one 32-bit word and pushes that word into a 64-entry receive FIFO. A downstream port drains the FIFO through a first-word-fall-through read side.

Two data words form a pair only if no other frame arrives between them. A run of data words that is closed by any non-data frame and that has odd length loses its final word, so the 32-bit alignment of everything that follows is kept. The framer raises one-cycle event pulses when this happens, when an invalid frame arrives, when a completed pair meets a full FIFO, and while the receiver link is not ready. Bit 0 of each control word carries the far end's almost-full state. The framer keeps that state as a level flag, and a software override can mask the flag.

Top module: `rxpf_rx_framer`

## Requirements
- R1: After reset, `fifo_empty` is 1, `fifo_half` is 0, all four event outputs are 0 and `remote_almost_full` is 0.
- R2: Two data frames (`frm_kind` = 2'b00) with no non-data frame between them become one FIFO entry. The first word goes to bits 15:0 and the second to bits 31:16. `fifo_empty` falls in the cycle after the second word is accepted.
- R3: When a control (2'b01), fill (2'b10) or invalid (2'b11) frame ends a data run of odd length, the unpaired word is discarded and `evt_odd_word` pulses for one cycle, in the cycle after the closing frame. The next data word starts a fresh pair. An even-length run raises no pulse.
- R4: An invalid frame (`frm_kind` = 2'b11) makes `evt_invalid` pulse for one cycle, in the cycle after it is accepted.
- R5: The FIFO returns entries in write order and holds 64 entries. `fifo_half` is 1 exactly when it holds 32 or more entries, and `fifo_empty` is 1 exactly when it holds none.
- R6: A pair that completes while the FIFO holds 64 entries is dropped. `evt_overflow` pulses in the next cycle, and the stored contents are unchanged.
- R7: A control frame loads its payload bit 0 into the remote almost-full flag, visible in the next cycle. Data and fill frames leave the flag unchanged.
- R8: While `remote_full_override` is 1, `remote_almost_full` reads 0 in the same cycle. Releasing the override shows the stored flag again.
- R9: `evt_link_down` is 1 in every cycle that follows a cycle in which `link_ready` was 0, and 0 otherwise.
- R10: A cycle with `path_reset` at 1 empties the FIFO and discards any half-assembled word, without raising `evt_odd_word`. The FIFO is empty in the next cycle.
- R11: A cycle with `frm_valid` at 0 is ignored whatever `frm_kind` and `frm_payload` hold. It produces no event, no FIFO write and no flag change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| path_reset | input | 1 | Synchronous clear of the pairing state and the FIFO |
| frm_valid | input | 1 | Frame present this cycle |
| frm_kind | input | 2 | Frame class: 00 data, 01 control, 10 fill, 11 invalid |
| frm_payload | input | 16 | Frame payload |
| link_ready | input | 1 | Receiver link ready level |
| remote_full_override | input | 1 | Forces the remote almost-full output to 0 while 1 |
| rd_en | input | 1 | Pop the head entry |
| rd_data | output | 32 | Head entry (first-word fall-through) |
| fifo_empty | output | 1 | FIFO holds no entry |
| fifo_half | output | 1 | FIFO holds 32 or more entries |
| remote_almost_full | output | 1 | Far-end almost-full flag, masked by the override |
| evt_invalid | output | 1 | Invalid frame event pulse |
| evt_odd_word | output | 1 | Unpaired data word dropped |
| evt_overflow | output | 1 | Pair dropped on a full FIFO |
| evt_link_down | output | 1 | Link not ready in the previous cycle |

## Verification
The pairing logic is tried with an isolated pair, and with odd runs closed in turn by a control, a fill and an invalid frame. It is also tried with an even run closed by a control frame, which shows whether only the unpaired word is dropped and whether the alignment of the next pair recovers. Filling the FIFO with distinct numbered pairs tells apart the half threshold at 31 and 32 entries, shows that an extra pair is dropped at 64, and confirms read order. A stale half word before a path reset shows whether the reset also clears the pairing state. Idle cycles that carry data and invalid codes show whether the valid qualifier is honoured.

// File: rtl/rxpf_pkg.sv
package rxpf_pkg;
  typedef enum logic [1:0] {
    KIND_DATA = 2'b00,
    KIND_CTRL = 2'b01,
    KIND_FILL = 2'b10,
    KIND_BAD  = 2'b11
  } frame_kind_e;
endpackage

// File: rtl/rxpf_pair_assembler.sv
module rxpf_pair_assembler
  import rxpf_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                in_valid,
  input  frame_kind_e         in_kind,
  input  logic [HALF_W-1:0]   in_data,
  input  logic                wr_ready,
  output logic                wr_en,
  output logic [2*HALF_W-1:0] wr_data,
  output logic                odd_evt,
  output logic                bad_evt,
  output logic                ovf_evt
);
  logic              half_vld_q, half_vld_d;
  logic [HALF_W-1:0] half_q;
  logic              half_load;
  logic              odd_c, bad_c, ovf_c, wr_c;

  always_comb begin
    half_vld_d = half_vld_q;
    half_load  = 1'b0;
    wr_c       = 1'b0;
    odd_c      = 1'b0;
    bad_c      = 1'b0;
    ovf_c      = 1'b0;
    if (clr) begin
      half_vld_d = 1'b0;
    end else if (in_valid) begin
      if (in_kind == KIND_DATA) begin
        if (!half_vld_q) begin
          half_load  = 1'b1;
          half_vld_d = 1'b1;
        end else begin
          half_vld_d = 1'b0;
          if (wr_ready) wr_c = 1'b1;
          else          ovf_c = 1'b1;
        end
      end else begin
        odd_c      = half_vld_q;
        half_vld_d = 1'b0;
        bad_c      = (in_kind == KIND_BAD);
      end
    end
  end

  assign wr_en   = wr_c;
  assign wr_data = {in_data, half_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_vld_q <= 1'b0;
      odd_evt    <= 1'b0;
      bad_evt    <= 1'b0;
      ovf_evt    <= 1'b0;
    end else begin
      half_vld_q <= half_vld_d;
      odd_evt    <= odd_c;
      bad_evt    <= bad_c;
      ovf_evt    <= ovf_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= '0;
    end else if (half_load) begin
      half_q <= in_data;
    end
  end
endmodule

// File: rtl/rxpf_word_fifo.sv
module rxpf_word_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full,
  output logic             half
);
  localparam int AW       = $clog2(DEPTH);
  localparam int CW       = AW + 1;
  localparam int HALF_LVL = DEPTH / 2;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             push, pop;

  assign push = wr_en && !full;
  assign pop  = rd_en && !empty;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (clr) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (push) wptr_d = (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
      if (pop)  rptr_d = (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
      if (push && !pop)      cnt_d = cnt_q + 1'b1;
      else if (pop && !push) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic entry_we;
    assign entry_we = push && !clr && (wptr_q == AW'(e));
    always_ff @(posedge clk) begin
      if (entry_we) mem[e] <= wr_data;
    end
  end

  assign rd_data = mem[rptr_q];
  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign half    = (cnt_q >= CW'(HALF_LVL));
endmodule

// File: rtl/rxpf_link_status.sv
module rxpf_link_status
  import rxpf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  frame_kind_e in_kind,
  input  logic        in_flag_bit,
  input  logic        override,
  input  logic        link_ready,
  output logic        remote_af,
  output logic        link_evt
);
  logic af_q, af_d, af_en;

  assign af_en = in_valid && (in_kind == KIND_CTRL);
  assign af_d  = in_flag_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      af_q     <= 1'b0;
      link_evt <= 1'b0;
    end else begin
      if (af_en) af_q <= af_d;
      link_evt <= !link_ready;
    end
  end

  assign remote_af = af_q && !override;
endmodule

// File: rtl/rxpf_rx_framer.sv
module rxpf_rx_framer
  import rxpf_pkg::*;
#(
  parameter int HALF_W     = 16,
  parameter int FIFO_DEPTH = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                path_reset,
  input  logic                frm_valid,
  input  logic [1:0]          frm_kind,
  input  logic [HALF_W-1:0]   frm_payload,
  input  logic                link_ready,
  input  logic                remote_full_override,
  input  logic                rd_en,
  output logic [2*HALF_W-1:0] rd_data,
  output logic                fifo_empty,
  output logic                fifo_half,
  output logic                remote_almost_full,
  output logic                evt_invalid,
  output logic                evt_odd_word,
  output logic                evt_overflow,
  output logic                evt_link_down
);
  localparam int WORD_W = 2 * HALF_W;

  frame_kind_e       kind;
  logic              wr_en, fifo_full;
  logic [WORD_W-1:0] wr_data;

  assign kind = frame_kind_e'(frm_kind);

  rxpf_pair_assembler #(.HALF_W(HALF_W)) i_pair (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (path_reset),
    .in_valid (frm_valid),
    .in_kind  (kind),
    .in_data  (frm_payload),
    .wr_ready (!fifo_full),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .odd_evt  (evt_odd_word),
    .bad_evt  (evt_invalid),
    .ovf_evt  (evt_overflow)
  );

  rxpf_word_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (path_reset),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .empty   (fifo_empty),
    .full    (fifo_full),
    .half    (fifo_half)
  );

  rxpf_link_status i_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (frm_valid),
    .in_kind     (kind),
    .in_flag_bit (frm_payload[0]),
    .override    (remote_full_override),
    .link_ready  (link_ready),
    .remote_af   (remote_almost_full),
    .link_evt    (evt_link_down)
  );
endmodule

// File: rtl/rxpf_rx_framer_chk.sv
module rxpf_rx_framer_chk #(
  parameter int HALF_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              path_reset,
  input logic              frm_valid,
  input logic [1:0]        frm_kind,
  input logic [HALF_W-1:0] frm_payload,
  input logic              link_ready,
  input logic              remote_full_override,
  input logic              fifo_empty,
  input logic              fifo_half,
  input logic              remote_almost_full,
  input logic              evt_invalid,
  input logic              evt_odd_word,
  input logic              evt_overflow,
  input logic              evt_link_down
);
  AST_INVALID_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_kind == 2'b11) |=> evt_invalid); // R4

  AST_HALF_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_half |-> !fifo_empty); // R5

  AST_OVERFLOW_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    evt_overflow |-> fifo_half); // R6

  AST_REMOTE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ((frm_valid && frm_kind == 2'b01) ##1 !remote_full_override)
      |-> (remote_almost_full == $past(frm_payload[0]))); // R7

  AST_OVERRIDE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    remote_full_override |-> !remote_almost_full); // R8

  AST_LINK_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !link_ready |=> evt_link_down); // R9

  AST_PATH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    path_reset |=> (fifo_empty && !evt_odd_word)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!frm_valid && !path_reset) |=> (!evt_invalid && !evt_odd_word && !evt_overflow)); // R11
endmodule

bind rxpf_rx_framer rxpf_rx_framer_chk #(.HALF_W(HALF_W)) i_chk (
  .clk                  (clk),
  .rst_n                (rst_n),
  .path_reset           (path_reset),
  .frm_valid            (frm_valid),
  .frm_kind             (frm_kind),
  .frm_payload          (frm_payload),
  .link_ready           (link_ready),
  .remote_full_override (remote_full_override),
  .fifo_empty           (fifo_empty),
  .fifo_half            (fifo_half),
  .remote_almost_full   (remote_almost_full),
  .evt_invalid          (evt_invalid),
  .evt_odd_word         (evt_odd_word),
  .evt_overflow         (evt_overflow),
  .evt_link_down        (evt_link_down)
);

// File: tb/test_rxpf_rx_framer.sv
module test_rxpf_rx_framer;
  logic        clk;
  logic        rst_n;
  logic        path_reset;
  logic        frm_valid;
  logic [1:0]  frm_kind;
  logic [15:0] frm_payload;
  logic        link_ready;
  logic        remote_full_override;
  logic        rd_en;
  logic [31:0] rd_data;
  logic        fifo_empty, fifo_half, remote_almost_full;
  logic        evt_invalid, evt_odd_word, evt_overflow, evt_link_down;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  localparam logic [1:0] K_DATA = 2'b00;
  localparam logic [1:0] K_CTRL = 2'b01;
  localparam logic [1:0] K_FILL = 2'b10;
  localparam logic [1:0] K_BAD  = 2'b11;

  rxpf_rx_framer i_rxpf_rx_framer (
    .clk(clk), .rst_n(rst_n), .path_reset(path_reset),
    .frm_valid(frm_valid), .frm_kind(frm_kind), .frm_payload(frm_payload),
    .link_ready(link_ready), .remote_full_override(remote_full_override),
    .rd_en(rd_en), .rd_data(rd_data), .fifo_empty(fifo_empty),
    .fifo_half(fifo_half), .remote_almost_full(remote_almost_full),
    .evt_invalid(evt_invalid), .evt_odd_word(evt_odd_word),
    .evt_overflow(evt_overflow), .evt_link_down(evt_link_down)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] k, input logic [15:0] p);
    @(negedge clk);
    frm_valid = 1'b1; frm_kind = k; frm_payload = p;
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic pop_check(input string req, input logic [31:0] exp);
    @(negedge clk);
    chk(req, rd_data, exp);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_path_reset();
    @(negedge clk);
    path_reset = 1'b1;
    @(negedge clk);
    path_reset = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 empty", fifo_empty, 1);
    chk("R1 half", fifo_half, 0);
    chk("R1 events", {evt_invalid, evt_odd_word, evt_overflow, evt_link_down}, 0);
    chk("R1 remote", remote_almost_full, 0);
  endtask

  task automatic t_pair();
    send(K_DATA, 16'h1111);
    chk("R2 empty after first half", fifo_empty, 1);
    send(K_DATA, 16'h2222);
    chk("R2 empty falls", fifo_empty, 0);
    pop_check("R2 order", 32'h2222_1111);
    chk("R2 empty after pop", fifo_empty, 1);
  endtask

  task automatic t_odd();
    send(K_DATA, 16'hAAAA);
    send(K_CTRL, 16'h0000);
    chk("R3 odd by ctrl", evt_odd_word, 1);
    chk("R3 dropped word", fifo_empty, 1);
    send(K_DATA, 16'h0003);
    send(K_DATA, 16'h0004);
    send(K_DATA, 16'h0005);
    send(K_FILL, 16'h0000);
    chk("R3 odd by fill", evt_odd_word, 1);
    send(K_DATA, 16'h0006);
    send(K_BAD, 16'h0000);
    chk("R3 odd by invalid", evt_odd_word, 1);
    send(K_DATA, 16'h0007);
    send(K_DATA, 16'h0008);
    send(K_CTRL, 16'h0000);
    chk("R3 even run no event", evt_odd_word, 0);
    pop_check("R3 realign first", 32'h0004_0003);
    pop_check("R3 realign second", 32'h0008_0007);
    chk("R3 nothing else kept", fifo_empty, 1);
  endtask

  task automatic t_invalid();
    send(K_BAD, 16'h1234);
    chk("R4 invalid event", evt_invalid, 1);
    @(negedge clk);
    chk("R4 single pulse", evt_invalid, 0);
    send(K_FILL, 16'h0000);
    chk("R4 fill not invalid", evt_invalid, 0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 64; i++) begin
      send(K_DATA, 16'(2 * i));
      send(K_DATA, 16'(2 * i + 1) | 16'h8000);
      if (i == 30) chk("R5 half clear at 31", fifo_half, 0);
      if (i == 31) chk("R5 half set at 32", fifo_half, 1);
    end
    send(K_DATA, 16'hDEAD);
    send(K_DATA, 16'hBEEF);
    chk("R6 overflow event", evt_overflow, 1);
    @(negedge clk);
    chk("R6 single pulse", evt_overflow, 0);
    for (int i = 0; i < 64; i++) begin
      pop_check("R5 order", {16'(2 * i + 1) | 16'h8000, 16'(2 * i)});
      if (i == 32) chk("R5 half clear at 31", fifo_half, 0);
    end
    chk("R6 extra pair dropped", fifo_empty, 1);
  endtask

  task automatic t_remote();
    send(K_CTRL, 16'h0001);
    chk("R7 flag set", remote_almost_full, 1);
    send(K_FILL, 16'h0000);
    chk("R7 fill keeps", remote_almost_full, 1);
    send(K_DATA, 16'h0000);
    send(K_DATA, 16'h0000);
    chk("R7 data keeps", remote_almost_full, 1);
    do_path_reset();
    @(negedge clk);
    remote_full_override = 1'b1;
    #1;
    chk("R8 override masks", remote_almost_full, 0);
    @(negedge clk);
    remote_full_override = 1'b0;
    #1;
    chk("R8 release restores", remote_almost_full, 1);
    send(K_CTRL, 16'hFFFE);
    chk("R7 flag cleared", remote_almost_full, 0);
  endtask

  task automatic t_link();
    @(negedge clk);
    link_ready = 1'b0;
    @(negedge clk);
    chk("R9 event first cycle", evt_link_down, 1);
    @(negedge clk);
    chk("R9 event held", evt_link_down, 1);
    link_ready = 1'b1;
    @(negedge clk);
    chk("R9 event ends", evt_link_down, 0);
  endtask

  task automatic t_path_reset();
    send(K_DATA, 16'h0101);
    send(K_DATA, 16'h0202);
    send(K_DATA, 16'h0303);
    chk("R10 entry before clear", fifo_empty, 0);
    do_path_reset();
    chk("R10 fifo cleared", fifo_empty, 1);
    chk("R10 no odd event", evt_odd_word, 0);
    send(K_DATA, 16'h0404);
    send(K_DATA, 16'h0505);
    pop_check("R10 half word discarded", 32'h0505_0404);
  endtask

  task automatic t_idle();
    @(negedge clk);
    frm_kind = K_BAD; frm_payload = 16'h0001;
    repeat (3) @(negedge clk);
    chk("R11 no invalid event", evt_invalid, 0);
    frm_kind = K_DATA;
    repeat (3) @(negedge clk);
    chk("R11 no write", fifo_empty, 1);
    frm_kind = K_CTRL;
    repeat (2) @(negedge clk);
    chk("R11 flag unchanged", remote_almost_full, 0);
    send(K_DATA, 16'h0909);
    send(K_CTRL, 16'h0000);
    chk("R11 idle did not pair", evt_odd_word, 1);
  endtask

  initial begin
    rst_n = 1'b0; path_reset = 1'b0; frm_valid = 1'b0; frm_kind = K_FILL;
    frm_payload = '0; link_ready = 1'b1; remote_full_override = 1'b0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pair();
    t_odd();
    t_invalid();
    t_fill();
    t_remote();
    t_link();
    t_path_reset();
    t_idle();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule